// File: doc/BRIEF.md
# SMRAM Window Remap Decoder

This block sits on the host memory path and decides, for each host address, whether the access belongs to the system-management RAM window. When it does, the block redirects the access to the physical DRAM address that backs the window. A byte-wide window control register selects one of four window layouts. A second byte mirrors the shadow setting of the E0000h region, and that byte can block three of the four layouts. An SMM-active input and a visibility bit in the control register decide whether the caller may see the window at all.

Both configuration bytes are loaded through one write port with a per-bit write mask. A lookup is presented on `host_addr` together with `smm_active`. The decision and the redirected address appear on registered outputs one clock later. The control register contents and its visibility bit are also brought out as outputs.

Top module: `smram_window_decoder`

## Requirements
- R1: Only bits 7, 6 and 4 of the control register can be stored. Any other bit written as 1 reads back as 0 on `ctrl_state`.
- R2: After reset the control register and the shadow byte are both 00h, so mode 0 is in effect and `win_open` is low.
- R3: Mode 0 (control bits 7:6 = 00) redirects host E0000h–E7FFFh onto physical E0000h–E7FFFh.
- R4: Mode 1 (bits 7:6 = 01) redirects host A0000h–A7FFFh onto physical E0000h–E7FFFh, keeping the offset. Other addresses miss.
- R5: Mode 2 (bits 7:6 = 10) redirects host B0000h–B7FFFh onto physical E0000h–E7FFFh, keeping the offset.
- R6: Mode 3 (bits 7:6 = 11) redirects host A0000h–AFFFFh onto the same physical addresses, whatever the value of the shadow byte.
- R7: In modes 0, 1 and 2, a nonzero shadow byte suppresses the window, and every address misses.
- R8: While `smm_active` is high, the window applies. While it is low, the window applies only if control bit 4 is set. `win_open` equals control bit 4.
- R9: When no window applies, `win_hit` is low and `phys_addr` equals the host address.
- R10: `win_hit` and `phys_addr` are registered. They reflect the lookup inputs and configuration present at the previous rising clock edge.
- R11: A configuration write changes only the bits whose `cfg_wmask` bit is 1. `cfg_sel` = 0 selects the control register and `cfg_sel` = 1 selects the shadow byte, and the register that is not selected is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: control register, 1: shadow byte |
| cfg_wdata | input | 8 | Write data |
| cfg_wmask | input | 8 | Per-bit write enable |
| smm_active | input | 1 | Host is in system-management mode |
| host_addr | input | 20 | Host access address |
| win_hit | output | 1 | Access falls in the active window |
| phys_addr | output | 20 | Redirected (or passed-through) address |
| win_open | output | 1 | Window also visible outside SMM |
| ctrl_state | output | 8 | Current control register value |

## Verification
A lookup result is due one rising edge after `host_addr` and `smm_active` are driven. A configuration write shows on `ctrl_state` and `win_open` after one edge, and it first affects a lookup at the edge after that. The bench therefore drives all inputs at the falling edge and samples at the next falling edge. In one directed check it also samples just before the edge, to confirm that the old result is still held there.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int SMR_AW    = 20;
    localparam int SMR_DW    = 8;
    localparam int SMR_MODES = 4;
    localparam logic [SMR_DW-1:0] SMR_CTRL_KEEP = 8'hD0;
    localparam int SMR_MODE_HI = 7;
    localparam int SMR_MODE_LO = 6;
    localparam int SMR_OPEN_BIT = 4;

    typedef logic [SMR_AW-1:0] haddr_t;
    typedef logic [SMR_DW-1:0] cfg_byte_t;

    typedef struct packed {
        haddr_t   host_base;
        haddr_t   phys_base;
        logic [4:0] size_log2;
        logic     needs_clear_shadow;
    } win_desc_t;

    function automatic win_desc_t window_of(input int m);
        win_desc_t w;
        case (m)
            0: w = '{host_base: 20'hE0000, phys_base: 20'hE0000, size_log2: 5'd15, needs_clear_shadow: 1'b1};
            1: w = '{host_base: 20'hA0000, phys_base: 20'hE0000, size_log2: 5'd15, needs_clear_shadow: 1'b1};
            2: w = '{host_base: 20'hB0000, phys_base: 20'hE0000, size_log2: 5'd15, needs_clear_shadow: 1'b1};
            default: w = '{host_base: 20'hA0000, phys_base: 20'hA0000, size_log2: 5'd16, needs_clear_shadow: 1'b0};
        endcase
        return w;
    endfunction

    typedef struct packed {
        cfg_byte_t ctrl;
        cfg_byte_t shadow;
    } cfg_state_t;

    typedef struct packed {
        logic   hit;
        haddr_t phys;
    } lookup_t;

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
#(
    parameter int DW = SMR_DW,
    parameter logic [DW-1:0] CTRL_KEEP = SMR_CTRL_KEEP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] shadow
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] shadow;
    } regs_t;

    regs_t regs_d, regs_q;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                            input logic [DW-1:0] new_v,
                                            input logic [DW-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (!sel) regs_d.ctrl   = merge(regs_q.ctrl, wdata, wmask) & CTRL_KEEP;
            else      regs_d.shadow = merge(regs_q.shadow, wdata, wmask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl   = regs_q.ctrl;
    assign shadow = regs_q.shadow;

    // R11: the register that is not selected keeps its value
    assert_ctrl_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> $stable(regs_q.ctrl));
    assert_shadow_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel) |=> $stable(regs_q.shadow));
    // R11: no write, no change
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
    // R1: masked-off control bits never get stored
    assert_ctrl_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl & ~CTRL_KEEP) == '0);

endmodule

// File: rtl/smram_window_map.sv
module smram_window_map
    import smram_pkg::*;
#(
    parameter int AW    = SMR_AW,
    parameter int DW    = SMR_DW,
    parameter int MODES = SMR_MODES
) (
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] shadow,
    input  logic          smm_active,
    input  logic [AW-1:0] host_addr,
    output logic          hit,
    output logic [AW-1:0] phys
);

    localparam int SELW = $clog2(MODES);

    logic [MODES-1:0] in_win;
    logic [MODES-1:0] allowed;
    logic [AW-1:0]    remap [MODES];
    logic [SELW-1:0]  mode;
    logic             access_ok;
    logic             shadow_clear;

    assign mode         = ctrl[SMR_MODE_HI:SMR_MODE_LO];
    assign shadow_clear = (shadow == '0);
    assign access_ok    = smm_active | ctrl[SMR_OPEN_BIT];

    for (genvar m = 0; m < MODES; m++) begin : g_mode
        localparam win_desc_t W = window_of(m);
        localparam int SZ = int'(W.size_log2);
        localparam logic [AW-1:0] OFS_MASK = (AW'(1) << SZ) - AW'(1);

        assign in_win[m]  = (host_addr[AW-1:SZ] == W.host_base[AW-1:SZ]);
        assign allowed[m] = !W.needs_clear_shadow || shadow_clear;
        assign remap[m]   = W.phys_base | (host_addr & OFS_MASK);
    end

    always_comb begin
        hit  = 1'b0;
        phys = host_addr;
        if (access_ok && in_win[mode] && allowed[mode]) begin
            hit  = 1'b1;
            phys = remap[mode];
        end
    end

endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
    import smram_pkg::*;
#(
    parameter int AW = SMR_AW,
    parameter int DW = SMR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [DW-1:0] cfg_wmask,
    input  logic          smm_active,
    input  logic [AW-1:0] host_addr,
    output logic          win_hit,
    output logic [AW-1:0] phys_addr,
    output logic          win_open,
    output logic [DW-1:0] ctrl_state
);

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] phys;
    } out_t;

    logic [DW-1:0] ctrl_w;
    logic [DW-1:0] shadow_w;
    logic          map_hit;
    logic [AW-1:0] map_phys;
    out_t          out_d, out_q;

    smram_cfg_regs #(.DW(DW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .wmask  (cfg_wmask),
        .ctrl   (ctrl_w),
        .shadow (shadow_w)
    );

    smram_window_map #(.AW(AW), .DW(DW)) u_map (
        .ctrl       (ctrl_w),
        .shadow     (shadow_w),
        .smm_active (smm_active),
        .host_addr  (host_addr),
        .hit        (map_hit),
        .phys       (map_phys)
    );

    always_comb begin
        out_d.hit  = map_hit;
        out_d.phys = map_phys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign win_hit    = out_q.hit;
    assign phys_addr  = out_q.phys;
    assign win_open   = ctrl_w[SMR_OPEN_BIT];
    assign ctrl_state = ctrl_w;

    // R9: a miss hands back the host address of the previous cycle
    assert_miss_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !win_hit) |-> phys_addr == $past(host_addr));
    // R8: a hit needs SMM or the visibility bit
    assert_access_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ($past(smm_active) || $past(ctrl_w[SMR_OPEN_BIT])));
    // R7: the 32 KB modes only hit with a clear shadow byte
    assert_shadow_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && $past(ctrl_w[SMR_MODE_HI:SMR_MODE_LO]) != 2'd3) |-> $past(shadow_w) == '0);
    // R3: every 32 KB mode lands in physical E0000h-E7FFFh
    assert_low_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && $past(ctrl_w[SMR_MODE_HI:SMR_MODE_LO]) != 2'd3) |-> phys_addr[AW-1:15] == 5'h1C);
    // R6: the 64 KB mode is an identity map of A0000h-AFFFFh
    assert_wide_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && $past(ctrl_w[SMR_MODE_HI:SMR_MODE_LO]) == 2'd3) |->
            (phys_addr == $past(host_addr) && phys_addr[AW-1:16] == 4'hA));

endmodule

// File: tb/test_smram_window_decoder.sv
module test_smram_window_decoder;

    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_wmask = '0;
    logic        smm_active = 1'b0;
    logic [19:0] host_addr = '0;
    logic        win_hit;
    logic [19:0] phys_addr;
    logic        win_open;
    logic [7:0]  ctrl_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(T/2) clk = ~clk;

    smram_window_decoder i_smram_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_wmask(cfg_wmask), .smm_active(smm_active),
        .host_addr(host_addr), .win_hit(win_hit), .phys_addr(phys_addr),
        .win_open(win_open), .ctrl_state(ctrl_state)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // {ctrl, shadow, smm, addr, exp_hit, exp_phys}
    localparam int NV = 17;
    localparam logic [57:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b1, 20'hE1234, 1'b1, 20'hE1234},  // R3
        {8'h00, 8'h00, 1'b1, 20'hE8000, 1'b0, 20'hE8000},  // R3 edge
        {8'h40, 8'h00, 1'b1, 20'hA7FFF, 1'b1, 20'hE7FFF},  // R4
        {8'h40, 8'h00, 1'b1, 20'hA8000, 1'b0, 20'hA8000},  // R4 edge
        {8'h80, 8'h00, 1'b1, 20'hB0010, 1'b1, 20'hE0010},  // R5
        {8'h80, 8'h00, 1'b1, 20'hA0010, 1'b0, 20'hA0010},  // R5 miss
        {8'hC0, 8'h00, 1'b1, 20'hAFFFF, 1'b1, 20'hAFFFF},  // R6
        {8'hC0, 8'h5A, 1'b1, 20'hA1234, 1'b1, 20'hA1234},  // R6 shadow ignored
        {8'hC0, 8'h00, 1'b1, 20'hB0000, 1'b0, 20'hB0000},  // R6 edge
        {8'h00, 8'h01, 1'b1, 20'hE0000, 1'b0, 20'hE0000},  // R7
        {8'h40, 8'h80, 1'b1, 20'hA0000, 1'b0, 20'hA0000},  // R7
        {8'h80, 8'h10, 1'b1, 20'hB0000, 1'b0, 20'hB0000},  // R7
        {8'h00, 8'h00, 1'b0, 20'hE0000, 1'b0, 20'hE0000},  // R8 closed
        {8'h10, 8'h00, 1'b0, 20'hE0004, 1'b1, 20'hE0004},  // R8 open
        {8'h50, 8'h00, 1'b0, 20'hA1000, 1'b1, 20'hE1000},  // R8 open mode 1
        {8'hD0, 8'h00, 1'b0, 20'hAFFF0, 1'b1, 20'hAFFF0},  // R8 open mode 3
        {8'h00, 8'h00, 1'b1, 20'h00000, 1'b0, 20'h00000}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_wmask = m;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wmask = '0;
    endtask

    task automatic lookup(input logic smm, input logic [19:0] a);
        @(negedge clk);
        smm_active = smm; host_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 ctrl", 32'(ctrl_state), 32'h00);
        check("R2 open", 32'(win_open), 32'h0);
        lookup(1'b1, 20'hE0100);
        check("R2 mode0 hit", 32'(win_hit), 32'h1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            cfg_write(1'b0, VEC[i][57:50], 8'hFF);
            cfg_write(1'b1, VEC[i][49:42], 8'hFF);
            lookup(VEC[i][41], VEC[i][40:21]);
            check($sformatf("R3-9 vec%0d hit", i), 32'(win_hit), 32'(VEC[i][20]));
            check($sformatf("R3-9 vec%0d phys", i), 32'(phys_addr), 32'(VEC[i][19:0]));
        end

        // R1: unkept bits dropped
        cfg_write(1'b0, 8'hFF, 8'hFF);
        check("R1 ctrl mask", 32'(ctrl_state), 32'hD0);
        check("R8 open flag", 32'(win_open), 32'h1);

        // R11: partial mask
        cfg_write(1'b0, 8'h00, 8'hFF);
        cfg_write(1'b0, 8'hFF, 8'h40);
        check("R11 masked bits", 32'(ctrl_state), 32'h40);
        cfg_write(1'b1, 8'h03, 8'hFF);
        check("R11 other reg kept", 32'(ctrl_state), 32'h40);
        cfg_write(1'b1, 8'h00, 8'h01);
        lookup(1'b1, 20'hA0000);
        check("R11 shadow bit1 kept so R7 blocks", 32'(win_hit), 32'h0);
        cfg_write(1'b1, 8'h00, 8'h02);
        lookup(1'b1, 20'hA0000);
        check("R11 shadow cleared", 32'(win_hit), 32'h1);

        // R10: result held until the edge
        @(negedge clk);
        host_addr = 20'h12345;
        #(T/2 - 2);
        check("R10 old result held", 32'(win_hit), 32'h1);
        @(negedge clk);
        check("R10 new result", 32'(win_hit), 32'h0);
        check("R10 new phys", 32'(phys_addr), 32'h12345);

        // R2: reset again clears config
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R2 ctrl after reset", 32'(ctrl_state), 32'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule